// File: doc/BRIEF.md
# Stepped-Trigger Readout Block Pattern Source

This block is a stimulus source for exercising a link deframer and the buffer that sits behind it. It plays one complete readout block as a stream of 16-bit words. Each word comes with a qualifier word that marks it as either a control word or a data word. Frames are four words long: two control words followed by two data words. A block is made of some idle frames, one event frame and a run of hit-data frames.

While it waits, the source loops over the first eight words of the block, which are the first two idle frames. After a trigger it finishes the current loop and plays the rest of the block once. The last word of the block comes with a one-cycle done pulse, and the source then goes back to the waiting loop. The hit data is either a running word count or the output of a 16-bit LFSR, chosen by a parameter.

Every output is computed from registered state only. A testbench can therefore compare each word against a formula for that word's position in the block.

Top module: `frame_pattern_src`

## Requirements
- R1: While reset is held, the outputs show word 0 of the block: the data word is 16'h0000, the qualifier is 16'h0004 and done is 0. After reset the event number is 0.
- R2: Word positions 0 and 1 of each frame carry qualifier 16'h0004, which has only bit 2 set and marks a control word. Positions 2 and 3 carry 16'h0002, which has only bit 1 set and marks a data word.
- R3: With no trigger, words 0 to 7 repeat in order without end.
- R4: Suppose the trigger is high on a clock edge that leaves one of words 0 to 7 on the outputs. After the next word 7, the source goes on to word 8 and then plays the block in order up to word 4*(N_IDLE+1+N_DATA)-1, which is word 1039 with the default parameters.
- R5: A trigger that arrives during playback, from word 8 onward, has no effect on the word order.
- R6: Control words of idle frames carry {8'h00, evt}, and their data words are 16'h0000. Control words of the event frame carry 16'h8000 | evt, and its data words carry {8'hE5, evt}. Here evt is the 8-bit event number.
- R7: A hit-frame control word is {2'b00, F, F, L, L, 2'b00, evt}. F is 1 only in the first hit frame and L is 1 only in the last one.
- R8: In counter mode, data slot s (2 or 3) of hit frame k carries 2k+s-1. This gives the values 1 to 2*N_DATA, so the last frame carries 511 and 512.
- R9: In LFSR mode, the hit words are successive states of a 16-bit Galois LFSR with taps 16'hB400, stepped as next = (x>>1) ^ (x[0] ? 16'hB400 : 0). The first hit word of every block is the seed (default 16'hACE1).
- R10: Done is high exactly on the last word of the block. The next word is word 0, and the event number then increments modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Trigger request, sampled on the clock edge |
| word_o | output | 16 | Frame word |
| qual_o | output | 16 | Qualifier word: bit 2 marks a control word, bit 1 marks a data word |
| done_o | output | 1 | High on the final word of a block |

## Verification
A word pointer that skips or repeats shows up on the very next word: a data value, a first or last flag, or a qualifier lands at a different position from the one the formula predicts. A lost or stray trigger arm changes where the stream leaves the eight-word loop, so word 8 appears at the wrong cycle or never appears. A wrong event number or LFSR state becomes visible on the next control word or the next hit word, at most four cycles later. A done pulse at the wrong time breaks the return to word 0 and the increment of the event number.

// File: rtl/frame_pattern_src.sv
module frame_pattern_src #(
  parameter int N_IDLE     = 3,
  parameter int N_DATA     = 256,
  parameter int LOOP_WORDS = 8,
  parameter bit LFSR_MODE  = 1'b0,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig,
  output logic [15:0] word_o,
  output logic [15:0] qual_o,
  output logic        done_o
);
  localparam int TOTAL = 4 * (N_IDLE + 1 + N_DATA);
  localparam int IW    = $clog2(TOTAL);
  localparam logic [IW-1:0] LOOP_LAST = IW'(LOOP_WORDS - 1);
  localparam logic [IW-1:0] EVT_BASE  = IW'(4 * N_IDLE);
  localparam logic [IW-1:0] HDR       = IW'(4 * (N_IDLE + 1));
  localparam logic [IW-1:0] END_IDX   = IW'(TOTAL - 1);
  localparam logic [IW-1:0] LAST_FR   = IW'(N_DATA - 1);

  logic [IW-1:0] idx;
  logic          armed;
  logic [7:0]    evt;
  logic [15:0]   lfsr;
  logic [15:0]   pat;

  wire           in_wait = idx <= LOOP_LAST;
  wire           at_end  = idx == END_IDX;
  wire           in_data = idx >= HDR;
  wire           evt_fr  = (idx >= EVT_BASE) && !in_data;
  wire           is_ctl  = ~idx[1];
  wire [IW-1:0]  frame   = (idx - HDR) >> 2;
  wire           first   = in_data && frame == '0;
  wire           last    = in_data && frame == LAST_FR;
  wire [15:0]    lfsr_nx = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      armed <= 1'b0;
      evt   <= '0;
      lfsr  <= SEED;
    end else begin
      if (in_wait) begin
        if (idx == LOOP_LAST) begin
          if (armed || trig) begin
            idx   <= idx + 1'b1;
            armed <= 1'b0;
          end else begin
            idx <= '0;
          end
        end else begin
          idx <= idx + 1'b1;
          if (trig) armed <= 1'b1;
        end
      end else if (at_end) begin
        idx <= '0;
        evt <= evt + 8'd1;
      end else begin
        idx <= idx + 1'b1;
      end

      if (at_end)                lfsr <= SEED;
      else if (in_data && !is_ctl) lfsr <= lfsr_nx;
    end
  end

  generate
    if (LFSR_MODE) begin : g_lfsr
      assign pat = lfsr;
    end else begin : g_count
      assign pat = 16'(frame) * 16'd2 + 16'(idx[0]) + 16'd1;
    end
  endgenerate

  wire [15:0] ctl_word  = {evt_fr, 1'b0, first, first, last, last, 2'b00, evt};
  wire [15:0] data_word = in_data ? pat : (evt_fr ? {8'hE5, evt} : 16'h0000);

  assign word_o = is_ctl ? ctl_word : data_word;
  assign qual_o = is_ctl ? 16'h0004 : 16'h0002;
  assign done_o = at_end;
endmodule

// File: rtl/frame_pattern_src_chk.sv
module frame_pattern_src_chk #(
  parameter int N_IDLE     = 3,
  parameter int N_DATA     = 256,
  parameter int LOOP_WORDS = 8,
  parameter int IW         = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic [15:0]   word_o,
  input logic [15:0]   qual_o,
  input logic          done_o,
  input logic [IW-1:0] idx,
  input logic          armed,
  input logic [7:0]    evt
);
  localparam logic [IW-1:0] LOOP_LAST = IW'(LOOP_WORDS - 1);

  a_r2_qual_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_o == 16'h0004) || (qual_o == 16'h0002));

  a_r3_loop_back: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == LOOP_LAST && !armed && !trig) |=> idx == '0);

  a_r4_trigger_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (idx < LOOP_LAST && trig) |=> armed);

  a_r5_playback_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (idx > LOOP_LAST && !done_o) |=> idx == $past(idx) + 1'b1);

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_o == 16'h0004 && word_o[13:12] == 2'b11) |-> word_o[11:10] == 2'b00);

  a_r10_done_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (idx == '0) && (evt == $past(evt) + 8'd1) && !done_o);
endmodule

bind frame_pattern_src frame_pattern_src_chk #(
  .N_IDLE(N_IDLE), .N_DATA(N_DATA), .LOOP_WORDS(LOOP_WORDS), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .word_o(word_o), .qual_o(qual_o),
  .done_o(done_o), .idx(idx), .armed(armed), .evt(evt)
);

// File: tb/frame_pattern_src_tb.sv
module frame_pattern_src_tb;
  localparam int N_IDLE = 3;
  localparam int N_DATA = 256;
  localparam int LOOPW  = 8;
  localparam int TOTAL  = 4 * (N_IDLE + 1 + N_DATA);
  localparam int HDR    = 4 * (N_IDLE + 1);
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic [15:0] w_c, q_c, w_l, q_l;
  logic d_c, d_l;

  always #2 clk = ~clk;

  frame_pattern_src #(.N_IDLE(N_IDLE), .N_DATA(N_DATA), .LOOP_WORDS(LOOPW),
    .LFSR_MODE(1'b0), .SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .word_o(w_c), .qual_o(q_c), .done_o(d_c));

  frame_pattern_src #(.N_IDLE(N_IDLE), .N_DATA(N_DATA), .LOOP_WORDS(LOOPW),
    .LFSR_MODE(1'b1), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .trig(trig), .word_o(w_l), .qual_o(q_l), .done_o(d_l));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int pos = 0;
  bit armed = 1'b0;
  logic [7:0] evt = 8'd0;
  logic [15:0] lf = SEED;
  bit just_left = 1'b0;
  bit ign_prev = 1'b0;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (word %0d)", tag, got, exp, pos);
    end
  endtask

  function automatic logic [15:0] exp_word(int p, logic [7:0] e, logic [15:0] l, bit lmode);
    int fr = p / 4;
    int sl = p % 4;
    bit ctl = sl < 2;
    int df;
    if (fr < N_IDLE) return ctl ? {8'h00, e} : 16'h0000;
    if (fr == N_IDLE) return ctl ? (16'h8000 | {8'h00, e}) : {8'hE5, e};
    df = fr - N_IDLE - 1;
    if (ctl) return {2'b00, (df == 0) ? 2'b11 : 2'b00, (df == N_DATA - 1) ? 2'b11 : 2'b00, 2'b00, e};
    return lmode ? l : 16'(df * 2 + sl - 1);
  endfunction

  function automatic string word_tag(bit lmode);
    if (just_left) return "R4";
    if (ign_prev)  return "R5";
    if (pos < LOOPW) return "R3";
    if (pos < HDR) return "R6";
    if (pos % 4 < 2) return "R7";
    return lmode ? "R9" : "R8";
  endfunction

  task automatic step(input bit tr);
    trig = tr;
    chk(word_tag(1'b0), w_c, exp_word(pos, evt, lf, 1'b0));
    chk(word_tag(1'b1), w_l, exp_word(pos, evt, lf, 1'b1));
    chk("R2", q_c, (pos % 4 < 2) ? 16'h0004 : 16'h0002);
    chk("R2", q_l, (pos % 4 < 2) ? 16'h0004 : 16'h0002);
    chk("R10", {15'd0, d_c}, {15'd0, pos == TOTAL - 1});
    chk("R10", {15'd0, d_l}, {15'd0, pos == TOTAL - 1});
    just_left = 1'b0;
    ign_prev  = tr && pos >= LOOPW;
    if (pos == TOTAL - 1) lf = SEED;
    else if (pos >= HDR && pos % 4 >= 2) lf = {1'b0, lf[15:1]} ^ (lf[0] ? 16'hB400 : 16'h0000);
    if (pos < LOOPW) begin
      if (pos == LOOPW - 1) begin
        if (armed || tr) begin pos = LOOPW; armed = 1'b0; just_left = 1'b1; end
        else pos = 0;
      end else begin
        pos++;
        if (tr) armed = 1'b1;
      end
    end else if (pos == TOTAL - 1) begin
      pos = 0;
      evt = evt + 8'd1;
    end else begin
      pos++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", w_c, 16'h0000);
    chk("R1", q_c, 16'h0004);
    chk("R1", {15'd0, d_c}, 16'd0);
    chk("R1", w_l, 16'h0000);
    rst_n = 1'b1;
    for (int i = 0; i < 21; i++) step(1'b0);
    for (int b = 0; b < 6; b++) begin
      if (b == 5) begin
        step(1'b1);
      end else begin
        for (int k = 0; k < (b * 3) % 8; k++) step(1'b0);
        step(1'b1);
      end
      while (pos != 0) begin
        if (b == 4) step(1'b1);
        else step((pos % 97) == 5);
      end
    end
    for (int i = 0; i < 12; i++) step(1'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule